// File: doc/BRIEF.md
# Posted Write Buffer Controller

This block sits between a system-bus target port and an expansion-bus master port. It handles memory writes that are bound for expansion memory. For each one it chooses between three outcomes: store the write and complete it at once, pass it through and hold the system side until the expansion cycle ends, or refuse it with a retry. The buffer holds one write: a 32-bit data word, its address and its byte enables.

The outcome depends on three things together: whether the buffer is occupied, whether the posting-enable configuration bit is set, and whether the expansion bus is busy. A write stored in the buffer is drained later as a single expansion-bus write. Memory reads and both I/O directions never enter the buffer. They are forwarded directly once the bus is free and the buffer is empty.

The system master holds its request until it sees ready or retry. The expansion side uses a one-cycle start pulse and later reports completion with a done strobe.

Top module: `pwb_ctrl`

## Requirements
- R1: After reset, sys_ready_o, sys_retry_o and exp_start_o are low and the buffer is empty, so the first eligible write is stored.
- R2: A memory write (command 4'b0111) is stored, and ready is given in the same cycle with no retry, when all of these hold: the buffer is empty, bit 2 of cfg_i is 1, and exp_busy_i is low. No other bit of cfg_i has any effect.
- R3: Memory-write-and-invalidate (command 4'b1111) is treated exactly like a memory write.
- R4: While the buffer holds a write, every memory write is answered with retry in the cycle it is presented.
- R5: With posting enabled, an empty buffer and exp_busy_i high, a memory write is answered with retry.
- R6: With posting disabled, an empty buffer and exp_busy_i low, a memory write is forwarded. exp_start_o pulses in the next cycle and carries the request's address, data and byte enables, with exp_write_o=1 and exp_io_o=0. Ready stays low until the cycle in which exp_done_i is high, and it is asserted in that cycle.
- R7: With posting disabled and exp_busy_i high, a memory write is answered with retry.
- R8: While the buffer is full, no cycle is in flight and exp_busy_i is low, a one-cycle exp_start_o pulse follows in the next cycle. The pulse carries the stored address, data and byte enables with exp_write_o=1 and exp_io_o=0. The buffer is empty from the cycle after exp_done_i.
- R9: Memory read (4'b0110), I/O read (4'b0010) and I/O write (4'b0011) never load the buffer. They are retried while the buffer is full or exp_busy_i is high. Otherwise they are forwarded as in R6, with exp_write_o=1 only for I/O write and exp_io_o=1 for both I/O codes. sys_rdata_o equals exp_rdata_i in the ready cycle.
- R10: Any other command code produces no ready, no retry and no expansion cycle.
- R11: sys_ready_o and sys_retry_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_i | input | CTRL_W | Control byte; bit POST_EN_BIT enables posting |
| sys_valid_i | input | 1 | System request present, held until ready or retry |
| sys_cmd_i | input | 4 | System bus command code |
| sys_addr_i | input | ADDR_W | Request address |
| sys_data_i | input | DATA_W | Write data |
| sys_be_i | input | DATA_W/8 | Byte enables |
| sys_ready_o | output | 1 | Request completed |
| sys_retry_o | output | 1 | Request refused, master must retry |
| sys_rdata_o | output | DATA_W | Read data, valid with ready |
| exp_busy_i | input | 1 | Expansion bus occupied |
| exp_done_i | input | 1 | Expansion cycle finished |
| exp_rdata_i | input | DATA_W | Expansion read data |
| exp_start_o | output | 1 | One-cycle expansion cycle start |
| exp_write_o | output | 1 | Expansion cycle direction, 1 = write |
| exp_io_o | output | 1 | Expansion cycle space, 1 = I/O |
| exp_addr_o | output | ADDR_W | Expansion cycle address |
| exp_data_o | output | DATA_W | Expansion write data |
| exp_be_o | output | DATA_W/8 | Expansion byte enables |

## Verification
The bench builds the block with ADDR_W=16 and keeps the default DATA_W=32 and a control byte with the posting bit at index 2. The narrower address makes it easy to pick distinct, recognisable addresses, while the full data width still exercises all four byte-enable lanes. The bench also varies the expansion latency and the timing of the busy signal. This reaches the cases where a drain is held off by a busy bus, where a write arrives while the buffer is full, and where a forwarded read returns its data on the same cycle as done.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  localparam logic [3:0] CMD_IO_RD   = 4'b0010;
  localparam logic [3:0] CMD_IO_WR   = 4'b0011;
  localparam logic [3:0] CMD_MEM_RD  = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR  = 4'b0111;
  localparam logic [3:0] CMD_MEM_WRI = 4'b1111;

  typedef enum logic [1:0] {CLS_NONE, CLS_MWR, CLS_PASS} cmd_cls_e;
  typedef enum logic [1:0] {LS_IDLE, LS_DRAIN, LS_FWD} lstate_e;

  function automatic cmd_cls_e classify(input logic [3:0] cmd);
    case (cmd)
      CMD_MEM_WR, CMD_MEM_WRI:         return CLS_MWR;
      CMD_MEM_RD, CMD_IO_RD, CMD_IO_WR: return CLS_PASS;
      default:                         return CLS_NONE;
    endcase
  endfunction
endpackage

// File: rtl/pwb_decide.sv
module pwb_decide
  import pwb_pkg::*;
(
  input  logic     valid_i,
  input  cmd_cls_e cls_i,
  input  logic     post_en_i,
  input  logic     busy_i,
  input  logic     full_i,
  input  logic     fwd_active_i,
  output logic     post_o,
  output logic     fwd_o,
  output logic     retry_o
);
  always_comb begin
    post_o  = 1'b0;
    fwd_o   = 1'b0;
    retry_o = 1'b0;
    if (valid_i && !fwd_active_i) begin
      case (cls_i)
        CLS_MWR: begin
          if (full_i)         retry_o = 1'b1;
          else if (busy_i)    retry_o = 1'b1;
          else if (post_en_i) post_o  = 1'b1;
          else                fwd_o   = 1'b1;
        end
        CLS_PASS: begin
          if (full_i || busy_i) retry_o = 1'b1;
          else                  fwd_o   = 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pwb_store.sv
module pwb_store #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              clear_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [BE_W-1:0]   be_i,
  output logic              full_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic [BE_W-1:0]   be_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_o <= 1'b0;
      addr_o <= '0;
      data_o <= '0;
      be_o   <= '0;
    end else if (load_i) begin
      full_o <= 1'b1;
      addr_o <= addr_i;
      data_o <= data_i;
      be_o   <= be_i;
    end else if (clear_i) begin
      full_o <= 1'b0;
    end
  end

  AST_NO_LOAD_WHEN_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !full_o); // R4
endmodule

// File: rtl/pwb_launch.sv
module pwb_launch
  import pwb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fwd_i,
  input  logic              fwd_write_i,
  input  logic              fwd_io_i,
  input  logic [ADDR_W-1:0] fwd_addr_i,
  input  logic [DATA_W-1:0] fwd_data_i,
  input  logic [BE_W-1:0]   fwd_be_i,
  input  logic              buf_full_i,
  input  logic [ADDR_W-1:0] buf_addr_i,
  input  logic [DATA_W-1:0] buf_data_i,
  input  logic [BE_W-1:0]   buf_be_i,
  input  logic              busy_i,
  input  logic              done_i,
  output lstate_e           state_o,
  output logic              buf_clear_o,
  output logic              fwd_done_o,
  output logic              start_o,
  output logic              write_o,
  output logic              io_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic [BE_W-1:0]   be_o
);
  lstate_e state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= LS_IDLE;
      start_o <= 1'b0;
      write_o <= 1'b0;
      io_o    <= 1'b0;
      addr_o  <= '0;
      data_o  <= '0;
      be_o    <= '0;
    end else begin
      start_o <= 1'b0;
      case (state_q)
        LS_IDLE: begin
          if (fwd_i) begin
            state_q <= LS_FWD;
            start_o <= 1'b1;
            write_o <= fwd_write_i;
            io_o    <= fwd_io_i;
            addr_o  <= fwd_addr_i;
            data_o  <= fwd_data_i;
            be_o    <= fwd_be_i;
          end else if (buf_full_i && !busy_i) begin
            // drain the posted write
            state_q <= LS_DRAIN;
            start_o <= 1'b1;
            write_o <= 1'b1;
            io_o    <= 1'b0;
            addr_o  <= buf_addr_i;
            data_o  <= buf_data_i;
            be_o    <= buf_be_i;
          end
        end
        LS_DRAIN: if (done_i) state_q <= LS_IDLE;
        LS_FWD:   if (done_i) state_q <= LS_IDLE;
        default:  state_q <= LS_IDLE;
      endcase
    end
  end

  assign state_o     = state_q;
  assign buf_clear_o = (state_q == LS_DRAIN) && done_i;
  assign fwd_done_o  = (state_q == LS_FWD) && done_i;

  AST_START_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o); // R8
  AST_START_IN_FLIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> state_q != LS_IDLE); // R6
  AST_FWD_NEEDS_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_i |-> !buf_full_i); // R6
endmodule

// File: rtl/pwb_ctrl.sv
module pwb_ctrl
  import pwb_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int CTRL_W      = 8,
  parameter int POST_EN_BIT = 2,
  localparam int BE_W       = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CTRL_W-1:0] cfg_i,
  input  logic              sys_valid_i,
  input  logic [3:0]        sys_cmd_i,
  input  logic [ADDR_W-1:0] sys_addr_i,
  input  logic [DATA_W-1:0] sys_data_i,
  input  logic [BE_W-1:0]   sys_be_i,
  output logic              sys_ready_o,
  output logic              sys_retry_o,
  output logic [DATA_W-1:0] sys_rdata_o,
  input  logic              exp_busy_i,
  input  logic              exp_done_i,
  input  logic [DATA_W-1:0] exp_rdata_i,
  output logic              exp_start_o,
  output logic              exp_write_o,
  output logic              exp_io_o,
  output logic [ADDR_W-1:0] exp_addr_o,
  output logic [DATA_W-1:0] exp_data_o,
  output logic [BE_W-1:0]   exp_be_o
);
  cmd_cls_e          cls;
  lstate_e           lstate;
  logic              dec_post, dec_fwd, dec_retry;
  logic              buf_full, buf_clear, fwd_done;
  logic              fwd_write, fwd_io;
  logic [ADDR_W-1:0] buf_addr;
  logic [DATA_W-1:0] buf_data;
  logic [BE_W-1:0]   buf_be;

  assign cls       = classify(sys_cmd_i);
  assign fwd_write = (cls == CLS_MWR) || (sys_cmd_i == CMD_IO_WR);
  assign fwd_io    = (sys_cmd_i == CMD_IO_RD) || (sys_cmd_i == CMD_IO_WR);

  pwb_decide u_decide (
    .valid_i      (sys_valid_i),
    .cls_i        (cls),
    .post_en_i    (cfg_i[POST_EN_BIT]),
    .busy_i       (exp_busy_i),
    .full_i       (buf_full),
    .fwd_active_i (lstate == LS_FWD),
    .post_o       (dec_post),
    .fwd_o        (dec_fwd),
    .retry_o      (dec_retry)
  );

  pwb_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (dec_post),
    .clear_i (buf_clear),
    .addr_i  (sys_addr_i),
    .data_i  (sys_data_i),
    .be_i    (sys_be_i),
    .full_o  (buf_full),
    .addr_o  (buf_addr),
    .data_o  (buf_data),
    .be_o    (buf_be)
  );

  pwb_launch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_launch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fwd_i       (dec_fwd),
    .fwd_write_i (fwd_write),
    .fwd_io_i    (fwd_io),
    .fwd_addr_i  (sys_addr_i),
    .fwd_data_i  (sys_data_i),
    .fwd_be_i    (sys_be_i),
    .buf_full_i  (buf_full),
    .buf_addr_i  (buf_addr),
    .buf_data_i  (buf_data),
    .buf_be_i    (buf_be),
    .busy_i      (exp_busy_i),
    .done_i      (exp_done_i),
    .state_o     (lstate),
    .buf_clear_o (buf_clear),
    .fwd_done_o  (fwd_done),
    .start_o     (exp_start_o),
    .write_o     (exp_write_o),
    .io_o        (exp_io_o),
    .addr_o      (exp_addr_o),
    .data_o      (exp_data_o),
    .be_o        (exp_be_o)
  );

  assign sys_ready_o = dec_post || fwd_done;
  assign sys_retry_o = dec_retry;
  assign sys_rdata_o = exp_rdata_i;

  AST_READY_RETRY_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sys_ready_o && sys_retry_o)); // R11
  AST_FULL_RETRIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_valid_i && cls == CLS_MWR && buf_full && lstate != LS_FWD) |-> sys_retry_o); // R4
  AST_POST_FILLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_ready_o && lstate != LS_FWD) |=> buf_full); // R2
  AST_PASS_NO_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_valid_i && cls == CLS_PASS) |=> !$rose(buf_full)); // R9
  AST_NOPOST_NO_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_valid_i && !cfg_i[POST_EN_BIT]) |=> !$rose(buf_full)); // R6
  AST_EMPTY_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lstate == LS_DRAIN && exp_done_i) |=> !buf_full); // R8
  AST_OTHER_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_valid_i && cls == CLS_NONE && lstate != LS_FWD) |-> !(sys_ready_o || sys_retry_o)); // R10
endmodule

// File: tb/pwb_ctrl_bench.sv
module pwb_ctrl_bench;
  localparam int AW = 16;
  localparam int DW = 32;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [7:0]    cfg_i = 8'h04;
  logic          sys_valid_i = 1'b0;
  logic [3:0]    sys_cmd_i = 4'h0;
  logic [AW-1:0] sys_addr_i = '0;
  logic [DW-1:0] sys_data_i = '0;
  logic [3:0]    sys_be_i = '0;
  logic          sys_ready_o, sys_retry_o;
  logic [DW-1:0] sys_rdata_o;
  logic          exp_busy_i = 1'b0;
  logic          exp_done_i = 1'b0;
  logic [DW-1:0] exp_rdata_i = '0;
  logic          exp_start_o, exp_write_o, exp_io_o;
  logic [AW-1:0] exp_addr_o;
  logic [DW-1:0] exp_data_o;
  logic [3:0]    exp_be_o;

  int total = 0;
  int bad = 0;
  int lat = 2;
  int cnt = 0;

  always #10 clk_i = ~clk_i;

  pwb_ctrl #(.ADDR_W(AW), .DATA_W(DW)) u_pwb_ctrl (
    .clk_i, .rst_ni, .cfg_i, .sys_valid_i, .sys_cmd_i, .sys_addr_i, .sys_data_i,
    .sys_be_i, .sys_ready_o, .sys_retry_o, .sys_rdata_o, .exp_busy_i, .exp_done_i,
    .exp_rdata_i, .exp_start_o, .exp_write_o, .exp_io_o, .exp_addr_o, .exp_data_o,
    .exp_be_o
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  // expansion responder: done arrives lat cycles after the start pulse
  always @(posedge clk_i) begin
    #1;
    if (cnt > 0) begin
      cnt = cnt - 1;
      exp_done_i = (cnt == 0);
      exp_rdata_i = {16'hC0DE, exp_addr_o};
    end else begin
      exp_done_i = 1'b0;
    end
    if (exp_start_o) cnt = lat;
  end

  // behavioural reference model, compared every cycle
  bit            m_full = 0;
  int            m_phase = 0; // 0 idle, 1 drain, 2 forward
  bit            m_start = 0;
  logic [AW-1:0] m_baddr, m_saddr;
  logic [DW-1:0] m_bdata, m_sdata;
  logic [3:0]    m_bbe, m_sbe;
  bit            m_swr, m_sio, m_rd;
  string         m_stag = "R1", m_ftag = "R6";

  always @(negedge clk_i) begin
    bit e_rdy, e_rty, nx_post, nx_fwd, nx_drain, w, p;
    string tag;
    if (rst_ni) begin
      e_rdy = 0; e_rty = 0; nx_post = 0; nx_fwd = 0; nx_drain = 0; tag = "R11";
      w = sys_valid_i && (sys_cmd_i == 4'h7 || sys_cmd_i == 4'hF);
      p = sys_valid_i && (sys_cmd_i == 4'h6 || sys_cmd_i == 4'h2 || sys_cmd_i == 4'h3);
      if (m_phase == 2) begin
        e_rdy = exp_done_i; tag = m_ftag;
      end else if (w) begin
        if (m_full) begin e_rty = 1; tag = "R4"; end
        else if (exp_busy_i) begin e_rty = 1; tag = cfg_i[2] ? "R5" : "R7"; end
        else if (cfg_i[2]) begin e_rdy = 1; nx_post = 1; tag = (sys_cmd_i == 4'hF) ? "R3" : "R2"; end
        else begin nx_fwd = 1; tag = "R6"; end
      end else if (p) begin
        tag = "R9";
        if (m_full || exp_busy_i) e_rty = 1; else nx_fwd = 1;
      end else if (sys_valid_i) tag = "R10";
      if (m_phase == 0 && m_full && !exp_busy_i) nx_drain = 1;

      chk(sys_ready_o === e_rdy, tag, "ready", 64'(sys_ready_o), 64'(e_rdy));
      chk(sys_retry_o === e_rty, tag, "retry", 64'(sys_retry_o), 64'(e_rty));
      chk(!(sys_ready_o && sys_retry_o), "R11", "ready&retry", 64'(sys_retry_o), 64'd0);
      chk(exp_start_o === m_start, m_stag, "start", 64'(exp_start_o), 64'(m_start));
      if (m_start) begin
        chk(exp_addr_o === m_saddr, m_stag, "exp_addr", 64'(exp_addr_o), 64'(m_saddr));
        chk(exp_data_o === m_sdata, m_stag, "exp_data", 64'(exp_data_o), 64'(m_sdata));
        chk(exp_be_o === m_sbe, m_stag, "exp_be", 64'(exp_be_o), 64'(m_sbe));
        chk(exp_write_o === m_swr, m_stag, "exp_write", 64'(exp_write_o), 64'(m_swr));
        chk(exp_io_o === m_sio, m_stag, "exp_io", 64'(exp_io_o), 64'(m_sio));
      end
      if (m_phase == 2 && exp_done_i && m_rd)
        chk(sys_rdata_o === exp_rdata_i, "R9", "rdata", 64'(sys_rdata_o), 64'(exp_rdata_i));

      m_start = 0;
      if (m_phase == 1 && exp_done_i) begin m_phase = 0; m_full = 0; end
      else if (m_phase == 2 && exp_done_i) m_phase = 0;
      else if (m_phase == 0) begin
        if (nx_fwd) begin
          m_phase = 2; m_start = 1; m_stag = tag; m_ftag = tag;
          m_saddr = sys_addr_i; m_sdata = sys_data_i; m_sbe = sys_be_i;
          m_swr = (sys_cmd_i != 4'h6 && sys_cmd_i != 4'h2);
          m_sio = (sys_cmd_i == 4'h2 || sys_cmd_i == 4'h3);
          m_rd  = !m_swr;
        end else if (nx_drain) begin
          m_phase = 1; m_start = 1; m_stag = "R8";
          m_saddr = m_baddr; m_sdata = m_bdata; m_sbe = m_bbe;
          m_swr = 1; m_sio = 0; m_rd = 0;
        end
      end
      if (nx_post) begin
        m_full = 1; m_baddr = sys_addr_i; m_bdata = sys_data_i; m_bbe = sys_be_i;
      end
    end
  end

  task automatic issue(input logic [3:0] cmd, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input logic [3:0] be, input int maxc);
    @(posedge clk_i); #1;
    sys_valid_i = 1; sys_cmd_i = cmd; sys_addr_i = a; sys_data_i = d; sys_be_i = be;
    for (int i = 0; i < maxc; i++) begin
      @(negedge clk_i);
      if (sys_ready_o || sys_retry_o) break;
    end
    @(posedge clk_i); #1;
    sys_valid_i = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1;
    @(negedge clk_i);
    chk(!sys_ready_o && !sys_retry_o && !exp_start_o, "R1", "reset outputs",
        {61'd0, sys_ready_o, sys_retry_o, exp_start_o}, 64'd0);
    // R2 post right after reset, then R4 while still full
    issue(4'h7, 16'h0100, 32'h11223344, 4'hF, 20);
    issue(4'hF, 16'h0104, 32'h55667788, 4'hC, 20);
    idle(8);
    // R3 invalidate variant posted
    issue(4'hF, 16'h0200, 32'hA5A5_0001, 4'h3, 20);
    idle(8);
    // R5 busy with posting enabled
    exp_busy_i = 1;
    issue(4'h7, 16'h0300, 32'hDEAD_0003, 4'hF, 20);
    exp_busy_i = 0;
    // R8 drain held while busy
    lat = 4;
    issue(4'h7, 16'h0400, 32'hBEEF_0004, 4'h1, 20);
    exp_busy_i = 1;
    idle(5);
    exp_busy_i = 0;
    idle(10);
    // R6 forward with posting disabled, other cfg bits set
    cfg_i = 8'hFB; lat = 3;
    issue(4'h7, 16'h0500, 32'h0000_0505, 4'h6, 20);
    idle(2);
    // R7 busy with posting disabled
    exp_busy_i = 1;
    issue(4'h7, 16'h0600, 32'h0000_0606, 4'hF, 20);
    exp_busy_i = 0;
    // R9 pass-through cycles
    issue(4'h6, 16'h0700, 32'h0, 4'hF, 20);
    idle(2);
    issue(4'h2, 16'h0080, 32'h0, 4'h1, 20);
    idle(2);
    issue(4'h3, 16'h0084, 32'h0000_00AB, 4'h1, 20);
    idle(2);
    cfg_i = 8'h04; lat = 5;
    issue(4'h7, 16'h0900, 32'h0909_0909, 4'hF, 20);
    issue(4'h6, 16'h0904, 32'h0, 4'hF, 20);
    idle(10);
    exp_busy_i = 1;
    issue(4'h3, 16'h0088, 32'h1, 4'h1, 20);
    exp_busy_i = 0;
    // R10 unknown command held several cycles
    issue(4'hC, 16'h0A00, 32'h0, 4'hF, 4);
    idle(4);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    bad++;
    $display("FAIL R11 watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule